// File: doc/BRIEF.md
# CAN Receive Queue with Selectable Overrun Policy

This block is a three-deep first-in first-out store for received CAN frames. The receive path hands it each accepted frame with a one-cycle write strobe. Software sees the oldest stored frame on the head output. When software has consumed that frame, it pulses a release strobe to discard it. A fill level, a full flag, a not-empty flag and a sticky overrun flag describe the queue's condition at all times.

A frame can arrive while all three places are taken. A policy input then selects which frame is lost. With the policy input low (replace policy), the arriving frame overwrites the youngest stored frame, so the two oldest frames survive. With the policy input high (keep policy), the arriving frame is dropped, and the three stored frames stay untouched. Either way the overrun flag is set, and it stays set until software acknowledges it.

The control is a three-state machine with the states `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. It moves along these transitions:
- `ST_EMPTY` to `ST_PARTIAL` is the first arrival.
- `ST_PARTIAL` to `ST_FULL` is the fill, when the last free place is written.
- `ST_PARTIAL` to `ST_EMPTY` is the drain, when the only frame is released.
- `ST_FULL` to `ST_PARTIAL` is the unfill, a release with no arrival.
- `ST_PARTIAL` holds while it sees arrivals, releases, or both at once, until one of them reaches an edge.
- `ST_FULL` holds on an overrun or on a combined arrival and release.

Top module: `can_rx_queue`

## Requirements
- R1: After reset, level is 0 and full, not_empty and overrun are all 0.
- R2: Frames leave in arrival order. head_frame shows the oldest stored frame. A release pulse while at least one frame is held removes that frame and lowers level (a binary count of held frames) by one in the next cycle.
- R3: full is 1 exactly when level equals 3, and level never exceeds 3.
- R4: With keep_mode at 0, an arrival while full replaces the youngest stored frame. Five arrivals with no release therefore leave frames 1, 2 and 5, read out in that order.
- R5: With keep_mode at 1, an arrival while full is discarded. Five arrivals with no release therefore leave frames 1, 2 and 3, and head and level do not change.
- R6: An arrival while full without a release sets overrun in the next cycle. overrun then stays 1 until an ovr_ack pulse. If an overrun and ovr_ack happen in the same cycle, overrun stays 1.
- R7: An arrival and a release in the same cycle while full act as a normal pop and push. Level stays 3, overrun does not rise, and the new frame becomes the youngest entry.
- R8: A release while empty has no effect. An arrival together with a release while empty stores the frame and gives level 1.
- R9: not_empty is 1 exactly when level is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle strobe: a received frame is on wr_frame |
| wr_frame | input | FRAME_W (32) | Received frame contents |
| rel | input | 1 | One-cycle strobe: software releases the head frame |
| keep_mode | input | 1 | Overrun policy: 0 replaces the youngest frame, 1 drops the arrival |
| ovr_ack | input | 1 | One-cycle strobe that clears the overrun flag |
| head_frame | output | FRAME_W (32) | Oldest stored frame; valid while not_empty is 1 |
| level | output | LVL_W (2) | Number of frames held |
| full | output | 1 | All three places are held |
| not_empty | output | 1 | At least one frame is held |
| overrun | output | 1 | Sticky: an arrival met a full queue |

## Verification
The bench first sends five back-to-back arrivals with no release, once under each policy. Reading the survivors back, frames 1, 2 and 5 versus frames 1, 2 and 3, shows that the policy input chooses which frame is lost. It also shows that both policies set the flag. A simultaneous arrival and release on a full queue separates a true overrun from a pop followed by a push. A release on an empty queue, alone and with an arrival, shows the release being ignored. A short partial fill and release checks arrival order and level counting away from the full boundary. Acknowledging the flag at the same moment as a new overrun shows that setting the flag wins over clearing it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Occupancy states of the queue controller
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } rxq_state_e;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH   = 3,
    parameter int FRAME_W = 32,
    parameter int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift,
    input  logic               we,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    output logic [FRAME_W-1:0] head_frame
);

    // Slot 0 is always the oldest frame; a pop moves every slot one place down.
    logic [FRAME_W-1:0] slot_q [DEPTH];
    logic [FRAME_W-1:0] slot_d [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [FRAME_W-1:0] moved;
        if (gi < DEPTH - 1) begin : g_mid
            assign moved = shift ? slot_q[gi+1] : slot_q[gi];
        end else begin : g_top
            assign moved = slot_q[gi];
        end
        assign slot_d[gi] = (we && (wr_idx == IDX_W'(gi))) ? wr_frame : moved;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[gi] <= '0;
            end else begin
                slot_q[gi] <= slot_d[gi];
            end
        end
    end

    assign head_frame = slot_q[0];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int LVL_W = $clog2(DEPTH + 1),
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rel,
    input  logic             keep_mode,
    input  logic             ovr_ack,
    output logic             shift,
    output logic             we,
    output logic [IDX_W-1:0] wr_idx,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             not_empty,
    output logic             overrun
);

    localparam logic [LVL_W-1:0] LVL_MAX  = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

    rxq_state_e       state_q, state_d;
    logic [LVL_W-1:0] cnt_q, cnt_d;
    logic             ovr_q, ovr_d, ovr_evt;

    // Next-state and storage command logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        shift   = 1'b0;
        we      = 1'b0;
        wr_idx  = '0;
        ovr_evt = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                // a release here has nothing to remove
                if (wr_en) begin
                    we      = 1'b1;
                    cnt_d   = LVL_ONE;
                    state_d = (DEPTH == 1) ? ST_FULL : ST_PARTIAL;
                end
            end
            ST_PARTIAL: begin
                if (wr_en && rel) begin
                    shift  = 1'b1;
                    we     = 1'b1;
                    wr_idx = IDX_W'(cnt_q - LVL_ONE);
                end else if (rel) begin
                    shift = 1'b1;
                    cnt_d = cnt_q - LVL_ONE;
                    if (cnt_q == LVL_ONE) begin
                        state_d = ST_EMPTY;
                    end
                end else if (wr_en) begin
                    we     = 1'b1;
                    wr_idx = IDX_W'(cnt_q);
                    cnt_d  = cnt_q + LVL_ONE;
                    if (cnt_q == LVL_MAX - LVL_ONE) begin
                        state_d = ST_FULL;
                    end
                end
            end
            ST_FULL: begin
                if (wr_en && rel) begin
                    shift  = 1'b1;
                    we     = 1'b1;
                    wr_idx = IDX_LAST;
                end else if (rel) begin
                    shift   = 1'b1;
                    cnt_d   = cnt_q - LVL_ONE;
                    state_d = (DEPTH == 1) ? ST_EMPTY : ST_PARTIAL;
                end else if (wr_en) begin
                    ovr_evt = 1'b1;
                    if (!keep_mode) begin
                        we     = 1'b1;
                        wr_idx = IDX_LAST;
                    end
                end
            end
            default: begin
                state_d = ST_EMPTY;
                cnt_d   = '0;
            end
        endcase
        ovr_d = ovr_evt ? 1'b1 : (ovr_ack ? 1'b0 : ovr_q);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ovr_q   <= ovr_d;
        end
    end

    // Outputs
    always_comb begin
        level     = cnt_q;
        full      = (state_q == ST_FULL);
        not_empty = (state_q != ST_EMPTY);
        overrun   = ovr_q;
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_MAX);                                                  // R3
    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        full == (level == LVL_MAX));                                        // R3
    AST_NE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        not_empty == (level != '0));                                        // R9
    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !wr_en && level != '0) |=> level == $past(level) - LVL_ONE); // R2
    AST_EMPTY_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !wr_en && level == '0) |=> level == '0);                    // R8
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rel) |=> overrun);                               // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_ack) |=> overrun);                                 // R6
    AST_BOTH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rel && full && !overrun) |=> (!overrun && full));         // R7

endmodule

// File: rtl/can_rx_queue.sv
module can_rx_queue #(
    parameter int DEPTH   = 3,
    parameter int FRAME_W = 32,
    parameter int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               rel,
    input  logic               keep_mode,
    input  logic               ovr_ack,
    output logic [FRAME_W-1:0] head_frame,
    output logic [LVL_W-1:0]   level,
    output logic               full,
    output logic               overrun,
    output logic               not_empty
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    logic             shift;
    logic             we;
    logic [IDX_W-1:0] wr_idx;

    rxq_ctrl #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rel       (rel),
        .keep_mode (keep_mode),
        .ovr_ack   (ovr_ack),
        .shift     (shift),
        .we        (we),
        .wr_idx    (wr_idx),
        .level     (level),
        .full      (full),
        .not_empty (not_empty),
        .overrun   (overrun)
    );

    rxq_store #(
        .DEPTH   (DEPTH),
        .FRAME_W (FRAME_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift      (shift),
        .we         (we),
        .wr_idx     (wr_idx),
        .wr_frame   (wr_frame),
        .head_frame (head_frame)
    );

    AST_KEEP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rel && keep_mode) |=> ($stable(head_frame) && level == LVL_MAX)); // R5
    AST_REPLACE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (DEPTH > 1 && full && wr_en && !rel && !keep_mode) |=> ($stable(head_frame) && full)); // R4

endmodule

// File: tb/sim_can_rx_queue.sv
module sim_can_rx_queue;

    localparam int FW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [FW-1:0] wr_frame = '0;
    logic          rel = 1'b0;
    logic          keep_mode = 1'b0;
    logic          ovr_ack = 1'b0;
    logic [FW-1:0] head_frame;
    logic [1:0]    level;
    logic          full, overrun, not_empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_frame(wr_frame), .rel(rel),
        .keep_mode(keep_mode), .ovr_ack(ovr_ack), .head_frame(head_frame),
        .level(level), .full(full), .overrun(overrun), .not_empty(not_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One-cycle strobe; outputs settle by the following negedge
    task automatic cyc(input logic w, input logic [FW-1:0] f, input logic r, input logic a);
        wr_en = w; wr_frame = f; rel = r; ovr_ack = a;
        @(negedge clk);
        wr_en = 1'b0; rel = 1'b0; ovr_ack = 1'b0;
    endtask

    task automatic drain3(input string req, input logic [FW-1:0] e0, input logic [FW-1:0] e1,
                          input logic [FW-1:0] e2);
        chk({req, " head0"}, head_frame, e0); cyc(1'b0, '0, 1'b1, 1'b0);
        chk({req, " head1"}, head_frame, e1); cyc(1'b0, '0, 1'b1, 1'b0);
        chk({req, " head2"}, head_frame, e2); cyc(1'b0, '0, 1'b1, 1'b0);
        chk({req, " drained level"}, 32'(level), 0);
    endtask

    task automatic t_reset_state();
        chk("R1 level", 32'(level), 0);
        chk("R1 full", 32'(full), 0);
        chk("R1 not_empty", 32'(not_empty), 0);
        chk("R1 overrun", 32'(overrun), 0);
    endtask

    task automatic t_order();
        cyc(1'b1, 32'h41, 1'b0, 1'b0);
        cyc(1'b1, 32'h42, 1'b0, 1'b0);
        chk("R2 level two", 32'(level), 2);
        chk("R3 not full at two", 32'(full), 0);
        chk("R9 not_empty", 32'(not_empty), 1);
        chk("R2 head oldest", head_frame, 32'h41);
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk("R2 level after pop", 32'(level), 1);
        chk("R2 head after pop", head_frame, 32'h42);
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk("R9 empty again", 32'(not_empty), 0);
    endtask

    task automatic t_replace();
        keep_mode = 1'b0;
        for (int i = 1; i <= 5; i++) cyc(1'b1, 32'(i), 1'b0, 1'b0);
        chk("R3 level full", 32'(level), 3);
        chk("R3 full flag", 32'(full), 1);
        chk("R6 overrun set", 32'(overrun), 1);
        drain3("R4", 32'd1, 32'd2, 32'd5);
        cyc(1'b0, '0, 1'b0, 1'b1);
        chk("R6 overrun cleared", 32'(overrun), 0);
    endtask

    task automatic t_keep();
        keep_mode = 1'b1;
        for (int i = 11; i <= 15; i++) cyc(1'b1, 32'(i), 1'b0, 1'b0);
        chk("R5 level", 32'(level), 3);
        chk("R5 overrun", 32'(overrun), 1);
        drain3("R5", 32'd11, 32'd12, 32'd13);
        cyc(1'b0, '0, 1'b0, 1'b1);
        keep_mode = 1'b0;
    endtask

    task automatic t_sticky();
        for (int i = 0; i < 4; i++) cyc(1'b1, 32'(50 + i), 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 1'b0);
        cyc(1'b1, 32'h60, 1'b0, 1'b0);
        chk("R6 sticky across traffic", 32'(overrun), 1);
        cyc(1'b1, 32'h61, 1'b0, 1'b1);
        chk("R6 set wins over ack", 32'(overrun), 1);
        cyc(1'b0, '0, 1'b0, 1'b1);
        chk("R6 ack clears", 32'(overrun), 0);
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, 1'b0);
    endtask

    task automatic t_both_full();
        cyc(1'b1, 32'h21, 1'b0, 1'b0);
        cyc(1'b1, 32'h22, 1'b0, 1'b0);
        cyc(1'b1, 32'h23, 1'b0, 1'b0);
        cyc(1'b1, 32'h24, 1'b1, 1'b0);
        chk("R7 no overrun", 32'(overrun), 0);
        chk("R7 level stays", 32'(level), 3);
        drain3("R7", 32'h22, 32'h23, 32'h24);
    endtask

    task automatic t_empty_release();
        cyc(1'b0, '0, 1'b1, 1'b0);
        chk("R8 release on empty level", 32'(level), 0);
        chk("R8 release on empty flag", 32'(not_empty), 0);
        cyc(1'b1, 32'h31, 1'b1, 1'b0);
        chk("R8 write with release level", 32'(level), 1);
        chk("R8 write with release head", head_frame, 32'h31);
        cyc(1'b0, '0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_order();
        t_replace();
        t_keep();
        t_sticky();
        t_both_full();
        t_empty_release();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule